// File: doc/BRIEF.md
# Programmable MMIO Window Decoder

This block holds the configuration of three address windows and tells, in the same cycle, which of them a system address falls into. Two windows are general memory-mapped I/O ranges whose size comes from a programmable mask. The third is a register window of fixed 4 KiB size. Each window has its own enable bit, and a window can only report a hit while that bit is set.

Software programs the bank through a 64-bit register port. Each access moves a full 8-byte register and selects it by a register index (byte address divided by 8). The port is always ready. A write is taken on the clock edge where `acc_valid` and `acc_we` are both high. Reads are combinational from `acc_off` and need no strobe. Each stored value keeps only the bits its register implements.

A write that touches the base or mask of a window that is currently enabled, or that targets an index with no register behind it, raises a one-cycle error pulse. After reset, the three window bases hold defaults computed from the chip and bridge index inputs. The effective base and size of every window are also driven out, so that neighbouring logic can use them.

Top module: `mmio_window_decoder`

## Requirements
- R1: Index 0 (window 0 base), index 1 (window 1 base), index 2 (window 0 mask) and index 3 (window 1 mask) store a written value with bits 29:0 forced to zero, keeping bits 63:30.
- R2: Index 4 (register window base) stores a written value with bits 25:0 forced to zero, keeping bits 63:26.
- R3: Index 5 (enable) keeps only bits 63:59. Bit 63 enables window 0, bit 62 enables window 1 and bit 61 enables the register window.
- R4: The effective base of a window is its stored base shifted right by 14. The size of window 0 or 1 is the bitwise inverse of its mask, shifted right by 14, plus one. The register window size is always 4096. These values appear on `win_base` and `win_size`.
- R5: `win_hit[i]` is high exactly when window i is enabled and base <= `sys_addr` < base + size. It follows `sys_addr` and the stored registers combinationally.
- R6: Writing the base or mask of an enabled window still stores the masked value and sets `acc_err` high in the following cycle only. Writing a window's registers while only a different window is enabled gives no error.
- R7: A write to an index from 6 to 15 changes no register and pulses `acc_err` in the following cycle. A read of such an index returns zero.
- R8: Synchronous active-low reset clears the enable register and loads the following values, each shifted left by 14 before storage:
  - window 0 base: 0x3d00000000000 + 0x4000000000·chip + 0x1000000000·bridge
  - window 1 base: 0x3ff8000000000 + 0x200000000·chip + 0x80000000·bridge
  - register window base: 0x3fffe40000000 + 0x400000·chip + 0x100000·bridge
  - window 0 mask: 0x3fff000000000
  - window 1 mask: 0x3ffff80000000

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_idx | input | CHIP_W | Chip index used for reset defaults |
| bridge_idx | input | BR_W | Bridge index used for reset defaults |
| acc_valid | input | 1 | Access strobe, always accepted |
| acc_we | input | 1 | Write when high together with acc_valid |
| acc_off | input | OFF_W | Register index (byte address / 8) |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Combinational read data for acc_off |
| acc_err | output | 1 | One-cycle pulse after an illegal write |
| sys_addr | input | 64 | Address checked against the windows |
| win_hit | output | 3 | Per-window hit |
| win_base | output | 3x64 | Per-window effective base |
| win_size | output | 3x64 | Per-window size |

## Verification
The hardest case to reach is an address sitting exactly on a window edge while the window's enable is in a known state. The bench programs the three windows to distinct, non-overlapping places through the register port. It then sweeps addresses at one below the base, the base, the last byte, one past the end and a middle point, first with all windows enabled and then with each window enabled on its own. The reset defaults are swept over every chip and bridge index pair, with a reset between pairs. The error conditions are reached by enabling one window at a time and then writing to both the owning registers and foreign registers.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int NWIN      = 3;
  localparam int NREG      = 6;
  localparam int OFF_BASE0 = 0;
  localparam int OFF_BASE1 = 1;
  localparam int OFF_MASK0 = 2;
  localparam int OFF_MASK1 = 3;
  localparam int OFF_RBASE = 4;
  localparam int OFF_EN    = 5;

  localparam logic [63:0] KEEP_MMIO  = 64'hFFFF_FFFF_C000_0000;
  localparam logic [63:0] KEEP_RBASE = 64'hFFFF_FFFF_FC00_0000;
  localparam logic [63:0] KEEP_EN    = 64'hF800_0000_0000_0000;

  localparam logic [63:0] REG_WIN_SIZE = 64'd4096;

  // Which stored bits a write keeps, per register index.
  function automatic logic [63:0] keep_mask(input int idx);
    case (idx)
      OFF_BASE0, OFF_BASE1, OFF_MASK0, OFF_MASK1: keep_mask = KEEP_MMIO;
      OFF_RBASE: keep_mask = KEEP_RBASE;
      OFF_EN:    keep_mask = KEEP_EN;
      default:   keep_mask = '0;
    endcase
  endfunction

  // Window that owns a register (NWIN for none).
  function automatic int owner_win(input int idx);
    case (idx)
      OFF_BASE0, OFF_MASK0: owner_win = 0;
      OFF_BASE1, OFF_MASK1: owner_win = 1;
      OFF_RBASE: owner_win = 2;
      default:   owner_win = NWIN;
    endcase
  endfunction
endpackage

// File: rtl/mwd_regbank.sv
module mwd_regbank
  import mwd_pkg::*;
#(
  parameter int CHIP_W = 3,
  parameter int BR_W   = 2,
  parameter int OFF_W  = 4,
  parameter int SHIFT  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] chip_idx,
  input  logic [BR_W-1:0]   bridge_idx,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       acc_rdata,
  output logic              acc_err,
  output logic [63:0]       regs_q [NREG],
  output logic [NWIN-1:0]   win_en
);
  localparam int IDX_W = $clog2(NREG);

  logic [63:0]     dflt [NREG];
  logic [NREG-1:0] wr_sel;
  logic            is_wr;
  logic            off_known;
  logic            conflict;
  logic            err_q;

  assign is_wr     = acc_valid && acc_we;
  assign off_known = (acc_off < OFF_W'(NREG));

  always_comb begin
    logic [63:0] c, b;
    c = 64'(chip_idx);
    b = 64'(bridge_idx);
    dflt[OFF_BASE0] = (64'h3d00000000000 + 64'h4000000000 * c + 64'h1000000000 * b) << SHIFT;
    dflt[OFF_BASE1] = (64'h3ff8000000000 + 64'h0200000000 * c + 64'h0080000000 * b) << SHIFT;
    dflt[OFF_RBASE] = (64'h3fffe40000000 + 64'h0000400000 * c + 64'h0000100000 * b) << SHIFT;
    dflt[OFF_MASK0] = 64'h3fff000000000 << SHIFT;
    dflt[OFF_MASK1] = 64'h3ffff80000000 << SHIFT;
    dflt[OFF_EN]    = '0;
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_en
    assign win_en[w] = regs_q[OFF_EN][63-w];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [63:0] KEEP = keep_mask(i);
    assign wr_sel[i] = is_wr && (acc_off == OFF_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)         regs_q[i] <= dflt[i];
      else if (wr_sel[i]) regs_q[i] <= acc_wdata & KEEP;
    end

    // R7: a write to an unknown index leaves every register untouched
    a_r7_unknown_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && !off_known) |=> $stable(regs_q[i]));
  end

  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (wr_sel[i] && owner_win(i) < NWIN && win_en[owner_win(i)]) conflict = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= is_wr && (!off_known || conflict);
  end
  assign acc_err = err_q;

  assign acc_rdata = off_known ? regs_q[acc_off[IDX_W-1:0]] : 64'd0;

  a_r7_unknown_err: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !off_known) |=> acc_err);
  a_r6_base0_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && acc_off == OFF_W'(OFF_BASE0) && regs_q[OFF_EN][63]) |=> acc_err);
  a_r6_rbase_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && acc_off == OFF_W'(OFF_RBASE) && regs_q[OFF_EN][61]) |=> acc_err);
  a_r3_en_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && acc_off == OFF_W'(OFF_EN)) |=> (regs_q[OFF_EN] == ($past(acc_wdata) & KEEP_EN)));
  a_r1_base0_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && acc_off == OFF_W'(OFF_BASE0)) |=> (regs_q[OFF_BASE0] == ($past(acc_wdata) & KEEP_MMIO)));
endmodule

// File: rtl/mwd_window.sv
module mwd_window #(
  parameter int          SHIFT      = 14,
  parameter logic [63:0] FIXED_SIZE = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [63:0] base_raw,
  input  logic [63:0] mask_raw,
  input  logic [63:0] addr,
  output logic [63:0] base,
  output logic [63:0] size,
  output logic        hit
);
  logic [64:0] limit;

  assign base  = base_raw >> SHIFT;
  assign size  = (FIXED_SIZE != '0) ? FIXED_SIZE : (((~mask_raw) >> SHIFT) + 64'd1);
  assign limit = {1'b0, base} + {1'b0, size};
  assign hit   = en && (addr >= base) && ({1'b0, addr} < limit);

  // R5: no hit from a disabled window, and never below the base
  a_r5_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (en && addr >= base));
endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
  import mwd_pkg::*;
#(
  parameter int CHIP_W = 3,
  parameter int BR_W   = 2,
  parameter int OFF_W  = 4,
  parameter int SHIFT  = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CHIP_W-1:0]     chip_idx,
  input  logic [BR_W-1:0]       bridge_idx,
  input  logic                  acc_valid,
  input  logic                  acc_we,
  input  logic [OFF_W-1:0]      acc_off,
  input  logic [63:0]           acc_wdata,
  output logic [63:0]           acc_rdata,
  output logic                  acc_err,
  input  logic [63:0]           sys_addr,
  output logic [NWIN-1:0]       win_hit,
  output logic [NWIN-1:0][63:0] win_base,
  output logic [NWIN-1:0][63:0] win_size
);
  logic [63:0]     regs [NREG];
  logic [NWIN-1:0] win_en;

  mwd_regbank #(
    .CHIP_W(CHIP_W), .BR_W(BR_W), .OFF_W(OFF_W), .SHIFT(SHIFT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .chip_idx(chip_idx), .bridge_idx(bridge_idx),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_off(acc_off),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
    .regs_q(regs), .win_en(win_en)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int          BI = (w == 0) ? OFF_BASE0 : (w == 1) ? OFF_BASE1 : OFF_RBASE;
    localparam int          MI = (w == 0) ? OFF_MASK0 : OFF_MASK1;
    localparam logic [63:0] FS = (w == 2) ? REG_WIN_SIZE : 64'd0;
    mwd_window #(.SHIFT(SHIFT), .FIXED_SIZE(FS)) u_win (
      .clk(clk), .rst_n(rst_n), .en(win_en[w]),
      .base_raw(regs[BI]), .mask_raw((w == 2) ? 64'd0 : regs[MI]),
      .addr(sys_addr), .base(win_base[w]), .size(win_size[w]), .hit(win_hit[w])
    );
  end

  // R8: the enable register comes out of reset cleared
  a_r8_no_hit_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (win_hit == '0));
endmodule

// File: tb/tb_mmio_window_decoder.sv
`timescale 1ns/1ps
module tb_mmio_window_decoder;
  logic clk = 0, rst_n = 0;
  logic [2:0] chip_idx = 0;
  logic [1:0] bridge_idx = 0;
  logic acc_valid = 0, acc_we = 0;
  logic [3:0] acc_off = 0;
  logic [63:0] acc_wdata = 0, acc_rdata, sys_addr = 0;
  logic acc_err;
  logic [2:0] win_hit;
  logic [2:0][63:0] win_base, win_size;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [63:0] KM = 64'hFFFF_FFFF_C000_0000;
  localparam logic [63:0] KR = 64'hFFFF_FFFF_FC00_0000;
  localparam logic [63:0] KE = 64'hF800_0000_0000_0000;

  always #5 clk = ~clk;

  mmio_window_decoder dut (.*);

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int off, input logic [63:0] d);
    @(negedge clk);
    acc_valid = 1; acc_we = 1; acc_off = 4'(off); acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_we = 0;
  endtask

  task automatic rd(input int off, output logic [63:0] d);
    acc_off = 4'(off); #1; d = acc_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  function automatic logic [63:0] msz(input logic [63:0] m);
    return ((~m) >> 14) + 64'd1;
  endfunction

  function automatic bit exp_hit(input bit en, input logic [63:0] a, input logic [63:0] b, input logic [63:0] s);
    return en && (a >= b) && ({1'b0, a} < ({1'b0, b} + {1'b0, s}));
  endfunction

  initial begin
    logic [63:0] v, d0, d1, dr, snap [6];
    logic [63:0] sb [3], ss [3], pts [5], pats [3];
    logic [63:0] st0, st1, stm0, stm1, str;
    bit en3 [3];

    // R8 / R4: defaults for every chip and bridge index pair
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 4; b++) begin
        chip_idx = 3'(c); bridge_idx = 2'(b);
        do_reset();
        d0 = (64'h3d00000000000 + 64'h4000000000 * c + 64'h1000000000 * b) << 14;
        d1 = (64'h3ff8000000000 + 64'h0200000000 * c + 64'h0080000000 * b) << 14;
        dr = (64'h3fffe40000000 + 64'h0000400000 * c + 64'h0000100000 * b) << 14;
        rd(0, v); chk("R8 base0 default", v, d0);
        rd(1, v); chk("R8 base1 default", v, d1);
        rd(4, v); chk("R8 rbase default", v, dr);
        rd(2, v); chk("R8 mask0 default", v, 64'h3fff000000000 << 14);
        rd(3, v); chk("R8 mask1 default", v, 64'h3ffff80000000 << 14);
        rd(5, v); chk("R8 enable cleared", v, 64'd0);
        chk("R8 err low", 64'(acc_err), 64'd0);
        chk("R8 no hit", 64'(win_hit), 64'd0);
        chk("R4 base0 out", win_base[0], d0 >> 14);
        chk("R4 rbase out", win_base[2], dr >> 14);
        chk("R4 size0 out", win_size[0], 64'h1000000000);
        chk("R4 reg window size", win_size[2], 64'd4096);
      end
    end

    // R1 / R2 / R3: kept bits per register
    chip_idx = 3'd2; bridge_idx = 2'd1;
    do_reset();
    pats[0] = '1; pats[1] = 64'hA5A5_5A5A_F0F0_0F0F; pats[2] = 64'h1234_5678_9ABC_DEF1;
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 4; o++) begin
        wr(o, pats[p]);
        chk("R1 no error while disabled", 64'(acc_err), 64'd0);
        rd(o, v); chk("R1 kept bits 63:30", v, pats[p] & KM);
      end
      wr(4, pats[p]); rd(4, v); chk("R2 kept bits 63:26", v, pats[p] & KR);
      wr(5, pats[p]); rd(5, v); chk("R3 kept bits 63:59", v, pats[p] & KE);
      wr(5, 64'd0);
    end
    wr(2, 64'hFFFF_FFFF_0000_0000);
    chk("R4 size from mask", win_size[0], 64'h40000);

    // R7: unknown indices
    for (int o = 6; o < 16; o++) begin
      for (int i = 0; i < 6; i++) rd(i, snap[i]);
      wr(o, '1);
      chk("R7 err pulse", 64'(acc_err), 64'd1);
      for (int i = 0; i < 6; i++) begin rd(i, v); chk("R7 registers unchanged", v, snap[i]); end
      rd(o, v); chk("R7 read zero", v, 64'd0);
      @(negedge clk); chk("R7 err one cycle", 64'(acc_err), 64'd0);
    end

    // R6: conflicts
    wr(5, 64'h8000_0000_0000_0000);
    wr(0, 64'h0004_0000_0000_0000);
    chk("R6 base0 while en0 err", 64'(acc_err), 64'd1);
    rd(0, v); chk("R6 value still stored", v, 64'h0004_0000_0000_0000);
    @(negedge clk); chk("R6 err one cycle", 64'(acc_err), 64'd0);
    wr(3, 64'hFFFF_FFFF_0000_0000);
    chk("R6 mask1 while only en0 no err", 64'(acc_err), 64'd0);
    wr(5, 64'h4000_0000_0000_0000);
    wr(3, 64'hFFFF_FFFF_0000_0000);
    chk("R6 mask1 while en1 err", 64'(acc_err), 64'd1);
    wr(4, 64'h000C_0000_0400_0000);
    chk("R6 rbase while only en1 no err", 64'(acc_err), 64'd0);
    wr(5, 64'h2000_0000_0000_0000);
    wr(4, 64'h000C_0000_0400_0000);
    chk("R6 rbase while en2 err", 64'(acc_err), 64'd1);
    wr(5, 64'h0800_0000_0000_0000);
    wr(2, 64'hFFFF_FFFF_C000_0000);
    chk("R6 unused enable bit no err", 64'(acc_err), 64'd0);

    // R5: window boundaries
    st0 = 64'h0004_0000_0000_0000; stm0 = 64'hFFFF_FFFF_C000_0000;
    st1 = 64'h0008_0000_0000_0000; stm1 = 64'hFFFF_FFFF_0000_0000;
    str = 64'h000C_0000_0400_0000;
    wr(5, 64'd0);
    wr(0, st0); wr(2, stm0); wr(1, st1); wr(3, stm1); wr(4, str);
    sb[0] = st0 >> 14; ss[0] = msz(stm0);
    sb[1] = st1 >> 14; ss[1] = msz(stm1);
    sb[2] = str >> 14; ss[2] = 64'd4096;
    for (int m = 0; m < 5; m++) begin
      logic [63:0] ev;
      ev = (m == 0) ? 64'hE000_0000_0000_0000 : (m == 4) ? 64'd0 : (64'h8000_0000_0000_0000 >> (m - 1));
      wr(5, ev);
      for (int k = 0; k < 3; k++) en3[k] = ev[63-k];
      for (int w = 0; w < 3; w++) begin
        pts[0] = sb[w] - 1; pts[1] = sb[w]; pts[2] = sb[w] + ss[w] - 1;
        pts[3] = sb[w] + ss[w]; pts[4] = sb[w] + (ss[w] >> 1);
        for (int p = 0; p < 5; p++) begin
          sys_addr = pts[p]; #1;
          for (int k = 0; k < 3; k++)
            chk($sformatf("R5 hit win%0d addr %h", k, pts[p]), 64'(win_hit[k]),
                64'(exp_hit(en3[k], pts[p], sb[k], ss[k])));
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule